// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block owns a small word-addressed register array and serves several requesters through a single serialized port. Each requester presents an opcode, a word address and an operand. The unit performs the whole read-modify-write of one operation as an indivisible pair of cycles. No other requester can read or write any word between the read and the write-back. For every operation, including plain loads and stores, the unit returns the word that held the address before the operation.

Requests use valid/ready handshaking, one channel per requester. A requester raises its valid with stable fields and keeps them unchanged until it sees its ready high at a rising clock edge. That edge is the handshake. Ready is only ever given to one valid requester at a time. Round-robin arbitration decides which one, so a requester that keeps valid high is never starved.

The response side has no back-pressure. The result appears as a one-cycle pulse carrying the requester index and the old word, and the receiver must take it in that cycle. The unit is meant to back lock words, counters and mailboxes shared by several engines.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset every memory word reads as 0, no response is pending and no ready is raised while no valid is high.
- R2: At most one ready is high in any cycle, and only for a requester whose valid is high.
- R3: Arbitration is round-robin: after requester i is accepted, the search for the next grant starts at requester i+1 (wrapping to 0).
- R4: A request accepted at edge k produces exactly one response, visible in the cycle between edges k+1 and k+2. In that cycle the response valid is high for one cycle, with the requester index and the word's value before the operation.
- R5: In the cycle after an acceptance (the read cycle) every ready is low. A new request can be accepted in the following cycle (the response/write cycle), so operations can issue every two cycles.
- R6: Opcode 0 (load) returns the word and leaves it unchanged.
- R7: Opcode 1 (store) writes the operand and returns the previous word.
- R8: Opcode 2 (test-and-set) returns the previous word and writes 1.
- R9: Opcode 3 (fetch-and-add) returns the previous word and writes the previous word plus the operand, wrapping modulo 2^DW without any flag.
- R10: Opcode 4 (swap) writes the operand and returns the previous word.
- R11: Opcode 5 (release) writes 0 and returns the previous word; the operand is ignored.
- R12: Opcodes 6 and 7 behave as a load: the word is returned and stays unchanged.
- R13: Read and write-back of one operation are indivisible. When all requesters fetch-and-add 1 to one word concurrently, the final value equals the number of such requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Per-requester request valid |
| req_ready | output | NREQ | Per-requester acceptance, at most one high |
| req_op | input | NREQ*3 | Opcode of requester i in bits [3i+2:3i] |
| req_addr | input | NREQ*AW | Word address of requester i in bits [AW*i+AW-1:AW*i] |
| req_data | input | NREQ*DW | Operand of requester i in bits [DW*i+DW-1:DW*i] |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_id | output | $clog2(NREQ) | Index of the requester being answered |
| rsp_data | output | DW | Word value before the operation |

## Verification
The hardest case to reach from the ports is a new acceptance landing in the write cycle of the previous operation on the same word. If that happens while write-back and the next read overlap wrongly, an increment is lost. To reach it, four concurrent drivers each issue a long run of fetch-and-add 1 to one shared address. Each driver re-raises valid as soon as its previous request is accepted, so the port stays saturated and back-to-back operations hit the same word continuously. A scoreboard then replays each response in arrival order against a model of the memory, and the final count is read back with a load.

// File: rtl/atom_pkg.sv
package atom_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_TAS   = 3'd2,
    OP_FADD  = 3'd3,
    OP_SWAP  = 3'd4,
    OP_CLR   = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RD   = 2'd1,
    PH_WR   = 2'd2
  } phase_e;
endpackage

// File: rtl/rmw_rr_arb.sv
module rmw_rr_arb #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          en,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gid,
  output logic          take
);
  logic [IW-1:0] ptr;
  logic          found;
  int            idx;

  // first valid requester at or after the pointer
  always_comb begin
    found = 1'b0;
    gid   = '0;
    idx   = 0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        found = 1'b1;
        gid   = IW'(idx);
      end
    end
  end

  assign take  = found & en;
  assign grant = take ? (N'(1) << gid) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (take) ptr <= (gid == IW'(N - 1)) ? '0 : gid + IW'(1);
  end
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import atom_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  old_val,
  input  logic [DW-1:0]  operand,
  output logic           wr_en,
  output logic [DW-1:0]  wr_val
);
  always_comb begin
    wr_en  = 1'b1;
    wr_val = old_val;
    case (op)
      OP_STORE, OP_SWAP: wr_val = operand;
      OP_TAS:            wr_val = DW'(1);
      OP_FADD:           wr_val = old_val + operand;
      OP_CLR:            wr_val = '0;
      default:           wr_en  = 1'b0;
    endcase
  end
endmodule

// File: rtl/rmw_store.sv
module rmw_store #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  assign rdata = words[raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (we) begin
      words[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atom_pkg::*;
#(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  parameter int DW   = 16,
  localparam int IDW = $clog2(NREQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREQ-1:0]   req_valid,
  output logic [NREQ-1:0]   req_ready,
  input  logic [NREQ*3-1:0] req_op,
  input  logic [NREQ*AW-1:0] req_addr,
  input  logic [NREQ*DW-1:0] req_data,
  output logic              rsp_valid,
  output logic [IDW-1:0]    rsp_id,
  output logic [DW-1:0]     rsp_data
);
  phase_e         phase;
  logic [OPW-1:0] op_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  opnd_q;
  logic [DW-1:0]  old_q;
  logic [IDW-1:0] id_q;

  logic [IDW-1:0] gid;
  logic           take;
  logic [OPW-1:0] sel_op;
  logic [AW-1:0]  sel_addr;
  logic [DW-1:0]  sel_data;
  logic [DW-1:0]  rd_word;
  logic           wr_en;
  logic [DW-1:0]  wr_val;

  // the port is free except during the read cycle of an operation
  rmw_rr_arb #(.N(NREQ), .IW(IDW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid), .en(phase != PH_RD),
    .grant(req_ready), .gid(gid), .take(take)
  );

  always_comb begin
    sel_op   = '0;
    sel_addr = '0;
    sel_data = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (gid == IDW'(i)) begin
        sel_op   = req_op[i*OPW +: OPW];
        sel_addr = req_addr[i*AW +: AW];
        sel_data = req_data[i*DW +: DW];
      end
    end
  end

  rmw_store #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .raddr(addr_q), .rdata(rd_word),
    .we(wr_en && phase == PH_WR), .waddr(addr_q), .wdata(wr_val)
  );

  rmw_alu #(.DW(DW)) u_alu (
    .op(op_q), .old_val(old_q), .operand(opnd_q),
    .wr_en(wr_en), .wr_val(wr_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      op_q   <= '0;
      addr_q <= '0;
      opnd_q <= '0;
      old_q  <= '0;
      id_q   <= '0;
    end else begin
      case (phase)
        PH_RD: begin
          old_q <= rd_word;
          phase <= PH_WR;
        end
        default: phase <= take ? PH_RD : PH_IDLE;
      endcase
      if (take) begin
        op_q   <= sel_op;
        addr_q <= sel_addr;
        opnd_q <= sel_data;
        id_q   <= gid;
      end
    end
  end

  assign rsp_valid = (phase == PH_WR);
  assign rsp_id    = id_q;
  assign rsp_data  = old_q;
endmodule

// File: rtl/atomic_rmw_chk.sv
module atomic_rmw_chk #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req_valid,
  input logic [N-1:0]  req_ready,
  input logic          rsp_valid,
  input logic [IW-1:0] rsp_id
);
  logic          hs;
  logic [IW-1:0] hs_id;

  always_comb begin
    hs    = |(req_valid & req_ready);
    hs_id = '0;
    for (int i = 0; i < N; i++) if (req_ready[i]) hs_id = IW'(i);
  end

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  // R2
  grant_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  // R5
  busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> (req_ready == '0));

  // R4
  rsp_after_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> ##1 (rsp_valid && rsp_id == $past(hs_id, 2)));

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R4
  rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(hs, 2));
endmodule

bind atomic_rmw_unit atomic_rmw_chk #(.N(NREQ), .IW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_id(rsp_id)
);

// File: tb/tb_atomic_rmw_unit.sv
module tb_atomic_rmw_unit;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int IW = $clog2(N);
  localparam int RUNS = 40;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic [N-1:0]      req_valid, req_ready;
  logic [N*3-1:0]    req_op;
  logic [N*AW-1:0]   req_addr;
  logic [N*DW-1:0]   req_data;
  logic              rsp_valid;
  logic [IW-1:0]     rsp_id;
  logic [DW-1:0]     rsp_data;

  logic          b_v    [N];
  logic [2:0]    b_op   [N];
  logic [AW-1:0] b_addr [N];
  logic [DW-1:0] b_data [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      req_valid[i]          = b_v[i];
      req_op[i*3 +: 3]      = b_op[i];
      req_addr[i*AW +: AW]  = b_addr[i];
      req_data[i*DW +: DW]  = b_data[i];
    end
  end

  atomic_rmw_unit #(.NREQ(N), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data)
  );

  typedef struct {
    logic [2:0]    op;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    int            cyc;
    string         tag;
  } item_t;

  item_t         pend [N][$];
  int            id_log [$];
  logic [DW-1:0] mdl [1 << AW];
  logic [DW-1:0] last_data;
  int            cyc = 0;
  int            checks = 0;
  int            errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R6";
      3'd1: return "R7";
      3'd2: return "R8";
      3'd3: return "R9";
      3'd4: return "R10";
      3'd5: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [DW-1:0] next_word(input logic [2:0] op,
      input logic [DW-1:0] old, input logic [DW-1:0] d);
    case (op)
      3'd1, 3'd4: return d;
      3'd2:       return DW'(1);
      3'd3:       return old + d;
      3'd5:       return '0;
      default:    return old;
    endcase
  endfunction

  // driver: holds valid until accepted, pushes the expected item at the handshake
  task automatic issue(input int id, input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input string tag = "");
    bit    hs;
    item_t it;
    @(negedge clk);
    b_v[id] = 1'b1; b_op[id] = op; b_addr[id] = a; b_data[id] = d;
    forever begin
      #1;
      hs     = req_ready[id];
      it.cyc = cyc;
      @(posedge clk);
      if (hs) break;
      @(negedge clk);
    end
    it.op = op; it.addr = a; it.data = d; it.tag = tag;
    pend[id].push_back(it);
    @(negedge clk);
    b_v[id] = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  task automatic fadd_run(input int id);
    for (int j = 0; j < RUNS; j++) issue(id, 3'd3, AW'(5), DW'(1), "R13");
  endtask

  // monitor: pops the issued item and compares against the memory model
  always @(negedge clk) begin
    item_t         it;
    logic [DW-1:0] exp;
    string         tag;
    if (rst_n && rsp_valid) begin
      if (pend[rsp_id].size() == 0) begin
        check(1'b0, "R4", "response without request", rsp_id, 0);
      end else begin
        it  = pend[rsp_id].pop_front();
        check(cyc == it.cyc + 2, "R4", "response latency", cyc - it.cyc, 2);
        exp = mdl[it.addr];
        tag = (it.tag != "") ? it.tag : op_tag(it.op);
        check(rsp_data == exp, tag, "old value", rsp_data, exp);
        mdl[it.addr] = next_word(it.op, exp, it.data);
      end
      id_log.push_back(int'(rsp_id));
      last_data = rsp_data;
    end
  end

  task automatic run_all();
    int exp_log [6] = '{1, 2, 3, 0, 1, 2};
    // R1: reset state
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    check(req_ready == '0, "R1", "ready with no valid", req_ready, 0);
    for (int a = 0; a < (1 << AW); a++) issue(0, 3'd0, AW'(a), 16'hFFFF, "R1");
    drain();

    // R3: rotation, pointer now at 1
    id_log.delete();
    fork
      issue(1, 3'd0, AW'(0), '0);
      issue(2, 3'd0, AW'(1), '0);
    join
    drain();
    fork
      issue(0, 3'd0, AW'(0), '0);
      issue(1, 3'd0, AW'(1), '0);
      issue(2, 3'd0, AW'(2), '0);
      issue(3, 3'd0, AW'(3), '0);
    join
    drain();
    check(id_log.size() == 6, "R3", "grant count", id_log.size(), 6);
    for (int i = 0; i < 6; i++)
      if (i < id_log.size())
        check(id_log[i] == exp_log[i], "R3", "grant order", id_log[i], exp_log[i]);

    // R5: no ready in read cycle, next accept in write cycle
    fork
      issue(0, 3'd0, AW'(4), '0);
      issue(1, 3'd0, AW'(6), '0);
      begin
        @(negedge clk); #1;
        check($countones(req_ready) == 1, "R5", "first accept", req_ready, 1);
        @(negedge clk); #1;
        check(req_ready == '0, "R5", "ready in read cycle", req_ready, 0);
        @(negedge clk); #1;
        check($countones(req_ready) == 1, "R5", "accept in write cycle", req_ready, 1);
      end
    join
    drain();

    // R7, R6, R10
    issue(1, 3'd1, AW'(3), 16'h1234);
    issue(2, 3'd0, AW'(3), '0);
    drain();
    check(last_data == 16'h1234, "R6", "load after store", last_data, 16'h1234);
    issue(3, 3'd4, AW'(3), 16'hBEEF);
    drain();
    check(last_data == 16'h1234, "R10", "swap old", last_data, 16'h1234);

    // R8 twice on one word
    issue(1, 3'd2, AW'(7), 16'h0005);
    issue(1, 3'd2, AW'(7), 16'h0005);
    drain();
    check(last_data == 16'h0001, "R8", "second test-and-set", last_data, 1);

    // R11
    issue(2, 3'd5, AW'(7), 16'h0055);
    issue(2, 3'd0, AW'(7), '0);
    drain();
    check(last_data == '0, "R11", "word after release", last_data, 0);

    // R12 reserved opcodes leave the word alone
    issue(3, 3'd6, AW'(3), 16'h7777);
    issue(3, 3'd7, AW'(3), 16'h0001);
    issue(0, 3'd0, AW'(3), '0);
    drain();
    check(last_data == 16'hBEEF, "R12", "word after reserved ops", last_data, 16'hBEEF);

    // R9 wrap
    issue(1, 3'd1, AW'(2), 16'hFFFF);
    issue(1, 3'd3, AW'(2), 16'h0003);
    issue(1, 3'd0, AW'(2), '0);
    drain();
    check(last_data == 16'h0002, "R9", "wrapped sum", last_data, 2);

    // R13 concurrent increments on one word
    issue(0, 3'd5, AW'(5), '0, "R13");
    fork
      fadd_run(0);
      fadd_run(1);
      fadd_run(2);
      fadd_run(3);
    join
    issue(0, 3'd0, AW'(5), '0, "R13");
    drain();
    check(last_data == DW'(N * RUNS), "R13", "final count", last_data, N * RUNS);

    for (int i = 0; i < N; i++)
      check(pend[i].size() == 0, "R4", "unanswered requests", pend[i].size(), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    for (int i = 0; i < N; i++) begin
      b_v[i] = 1'b0; b_op[i] = '0; b_addr[i] = '0; b_data[i] = '0;
    end
    for (int a = 0; a < (1 << AW); a++) mdl[a] = '0;
    last_data = '0;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R13 watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule